// File: doc/BRIEF.md
# Eleven-Pin GPIO Port Controller

This block controls an eleven-pin general-purpose I/O port through three 32-bit registers on a simple synchronous register bus. The three registers hold a per-pin mode, the per-pin data and a per-pin pull-down disable. For each pin, the mode selects one of four behaviours:

- plain input;
- driven output;
- pass-through of an alternate signal pair (output value and output enable) supplied by an internal peripheral;
- reserved.

The block drives each pad's output value and output enable and produces an active-high pull-down enable for each pad. It also returns the synchronized pad levels, both to the alternate peripherals and through data-register reads.

Bus requests are accepted every cycle and there is no back-pressure. A read takes one cycle: its response, flagged by `rsp_valid`, appears in the cycle after the request, and the requester cannot stall it. Reads return the whole 32-bit word whatever the byte enables are. Writes update only the byte lanes whose enable bit is set. The bus is little-endian, so an 8-bit access at a register's base offset reaches bits 7:0.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the mode and pull-down registers read zero, every pad has output enable low and output value low, and every pull-down enable is high.
- R2: The mode of pin n is held in bits [2n+1:2n] of the register at offset 0x0. Code 00 is input, 01 is output, 10 is alternate and 11 is reserved. In output mode the pad output enable is high.
- R3: In output mode, pad output equals that pin's bit of the data register (offset 0x4, bit n for pin n): 1 drives high and 0 drives low. A data read returns the written bit for such a pin.
- R4: For pins in input mode, a data read returns the pad level after a two-flop synchronizer. A pad change is visible to a read issued two cycles later.
- R5: In alternate mode, pad output and output enable follow `alt_out` and `alt_oe`, and a data read returns the synchronized pad level. `alt_in` always carries the synchronized pad levels.
- R6: In reserved mode the pad output enable is low and a data read returns the synchronized pad level.
- R7: Bit n of the register at offset 0x8 set to 1 disables pin n's pull-down (`pad_pd_en[n]` low). When the bit is 0, the pull-down is enabled.
- R8: A write changes only the byte lanes whose `req_be` bit is set. Bit 0 of `req_be` selects bits 7:0.
- R9: Register bits above the implemented fields read as zero and ignore writes. Offsets other than 0x0, 0x4 and 0x8 read as zero and writes to them change nothing.
- R10: `rsp_valid` is high exactly in the cycle after an accepted read request, and never after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset from port base |
| req_be | input | 4 | Write byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | 11 | Raw pad levels |
| pad_out | output | 11 | Pad output values |
| pad_oe | output | 11 | Pad output enables |
| pad_pd_en | output | 11 | Pull-down enables, active high |
| alt_out | input | 11 | Alternate-function output values |
| alt_oe | input | 11 | Alternate-function output enables |
| alt_in | output | 11 | Synchronized pad levels to peripherals |

## Verification
Corrupt mode state shows at once on `pad_oe` and `pad_out` without any bus traffic, because the pin multiplexer is purely combinational from the registers. Corrupt data or pull-down state shows on `pad_out` or `pad_pd_en` in the cycle after the write that should have set it. A fault in the synchronizer or read multiplexing shows only through a read response, one cycle after the read request. The bench therefore pairs each register write with both an immediate pad check and a readback.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    PM_IN   = 2'b00,
    PM_OUT  = 2'b01,
    PM_ALT  = 2'b10,
    PM_RSVD = 2'b11
  } pin_mode_e;

  localparam int unsigned WIDX_CFG = 0;
  localparam int unsigned WIDX_DAT = 1;
  localparam int unsigned WIDX_PD  = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;

  // warm-up counter so the two-cycle look-back never reaches before reset
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  p_two_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2) |-> d_sync == $past(d_in, 2));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 11
) (
  input  logic [2*NPINS-1:0] cfg,
  input  logic [NPINS-1:0]   dat,
  input  logic [NPINS-1:0]   alt_out,
  input  logic [NPINS-1:0]   alt_oe,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_mode_e mode;
    assign mode = pin_mode_e'(cfg[2*p +: 2]);

    always_comb begin
      unique case (mode)
        PM_OUT:  begin pad_out[p] = dat[p];     pad_oe[p] = 1'b1;      end
        PM_ALT:  begin pad_out[p] = alt_out[p]; pad_oe[p] = alt_oe[p]; end
        default: begin pad_out[p] = 1'b0;       pad_oe[p] = 1'b0;      end
      endcase
    end

    always_comb begin
      if (mode == PM_RSVD) p_rsvd_no_oe_r6: assert (!pad_oe[p]);
      if (mode == PM_IN)   p_in_no_oe_r2:   assert (!pad_oe[p]);
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS  = 11,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW/8-1:0]   req_be,
  input  logic [DW-1:0]     req_wdata,
  input  logic [NPINS-1:0]  pin_level,
  output logic [2*NPINS-1:0] cfg_q,
  output logic [NPINS-1:0]  dat_q,
  output logic [NPINS-1:0]  pd_dis_q,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata
);
  localparam int unsigned CFG_W  = 2 * NPINS;
  localparam int unsigned NBYTES = DW / 8;
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [DW-1:0]     lane_mask;
  logic [WIDX_W-1:0] widx;
  logic              wr_en, rd_en;
  logic [NPINS-1:0]  dat_view;
  logic [DW-1:0]     rd_word;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane_mask[8*b +: 8] = {8{req_be[b]}};
  end

  assign widx  = req_addr[ADDR_W-1:2];
  assign wr_en = req_valid && req_write;
  assign rd_en = req_valid && !req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      dat_q    <= '0;
      pd_dis_q <= '0;
    end else if (wr_en) begin
      if (widx == WIDX_W'(WIDX_CFG))
        cfg_q <= (cfg_q & ~lane_mask[CFG_W-1:0]) | (req_wdata[CFG_W-1:0] & lane_mask[CFG_W-1:0]);
      if (widx == WIDX_W'(WIDX_DAT))
        dat_q <= (dat_q & ~lane_mask[NPINS-1:0]) | (req_wdata[NPINS-1:0] & lane_mask[NPINS-1:0]);
      if (widx == WIDX_W'(WIDX_PD))
        pd_dis_q <= (pd_dis_q & ~lane_mask[NPINS-1:0]) | (req_wdata[NPINS-1:0] & lane_mask[NPINS-1:0]);
    end
  end

  always_comb begin
    for (int p = 0; p < NPINS; p++)
      dat_view[p] = (pin_mode_e'(cfg_q[2*p +: 2]) == PM_OUT) ? dat_q[p] : pin_level[p];
  end

  always_comb begin
    rd_word = '0;
    if (widx == WIDX_W'(WIDX_CFG))      rd_word[CFG_W-1:0] = cfg_q;
    else if (widx == WIDX_W'(WIDX_DAT)) rd_word[NPINS-1:0] = dat_view;
    else if (widx == WIDX_W'(WIDX_PD))  rd_word[NPINS-1:0] = pd_dis_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_rdata <= rd_en ? rd_word : '0;
    end
  end

  p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);
  p_no_rsp_otherwise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid);
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rdata[DW-1:CFG_W] == '0);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int unsigned NPINS  = 11,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW/8-1:0]   req_be,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pd_en,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic [NPINS-1:0]  alt_in
);
  logic [NPINS-1:0]   pin_level;
  logic [2*NPINS-1:0] cfg_q;
  logic [NPINS-1:0]   dat_q;
  logic [NPINS-1:0]   pd_dis_q;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_sync(pin_level)
  );

  gpio_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .pin_level(pin_level),
    .cfg_q(cfg_q), .dat_q(dat_q), .pd_dis_q(pd_dis_q),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  gpio_pin_mux #(.NPINS(NPINS)) u_mux (
    .cfg(cfg_q), .dat(dat_q), .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign pad_pd_en = ~pd_dis_q;
  assign alt_in    = pin_level;

  p_pd_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[ADDR_W-1:2] == 2 && req_be[0])
      |=> pad_pd_en[7:0] == ~$past(req_wdata[7:0]));
  p_out_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[ADDR_W-1:2] == 1 && req_be[0] && cfg_q[1:0] == 2'b01)
      |=> pad_out[0] == $past(req_wdata[0]));
endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [10:0] pad_in = '0, alt_out = '0, alt_oe = '0;
  logic [10:0] pad_out, pad_oe, pad_pd_en, alt_in;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd_en(pad_pd_en),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R10 no response after write", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic bus_read(logic [5:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = 4'hF;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rsp_rdata, e);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", {21'd0, pad_oe}, 32'd0);
    check("R1 pad_out", {21'd0, pad_out}, 32'd0);
    check("R1 pad_pd_en", {21'd0, pad_pd_en}, 32'h7FF);
    bus_read(6'h00, 32'h0, "R1 mode reg");
    bus_read(6'h08, 32'h0, "R1 pulldown reg");
    // R4 input pins follow pad after sync
    pad_in = 11'h5A5;
    repeat (2) @(negedge clk);
    bus_read(6'h04, 32'h5A5, "R4 input read");
    // R2 modes: pins0-2 out, pin3 alt, pin4 reserved
    alt_out = 11'h008; alt_oe = 11'h008;
    bus_write(6'h00, 4'hF, 32'h0000_0395);
    bus_write(6'h04, 4'hF, 32'h0000_0005);
    check("R2 R5 R6 pad_oe", {21'd0, pad_oe}, 32'h00F);
    check("R3 R5 pad_out", {21'd0, pad_out}, 32'h00D);
    alt_oe = 11'h000; #1;
    check("R5 alt_oe follows", {21'd0, pad_oe}, 32'h007);
    pad_in = 11'h7F0;
    repeat (2) @(negedge clk);
    check("R5 alt_in", {21'd0, alt_in}, 32'h7F0);
    bus_read(6'h04, 32'h7F5, "R3 R5 R6 mixed data read");
    bus_read(6'h00, 32'h395, "R2 mode readback");
    // R7 pull-downs, R9 upper bits
    bus_write(6'h08, 4'hF, 32'h0000_0F0F);
    check("R7 pad_pd_en", {21'd0, pad_pd_en}, 32'h0F0);
    bus_read(6'h08, 32'h70F, "R9 pulldown upper bits");
    // R8 byte lanes
    bus_write(6'h00, 4'b0001, 32'hFFFF_FFFF);
    bus_read(6'h00, 32'h3FF, "R8 byte0 mode write");
    check("R6 reserved pins no oe", {21'd0, pad_oe}, 32'h000);
    bus_write(6'h04, 4'b0010, 32'hFFFF_FFFF);
    bus_write(6'h00, 4'hF, 32'h0015_5555);
    check("R8 R3 pad_out lane1", {21'd0, pad_out}, 32'h705);
    check("R2 all out oe", {21'd0, pad_oe}, 32'h7FF);
    bus_read(6'h04, 32'h705, "R3 output readback");
    // R9 out-of-range
    bus_write(6'h0C, 4'hF, 32'hFFFF_FFFF);
    bus_write(6'h10, 4'hF, 32'hFFFF_FFFF);
    bus_read(6'h0C, 32'h0, "R9 hole read");
    bus_read(6'h10, 32'h0, "R9 hole read 2");
    bus_read(6'h00, 32'h15_5555, "R9 mode unchanged");
    bus_read(6'h08, 32'h70F, "R9 pulldown unchanged");
    check("R9 pad_out unchanged", {21'd0, pad_out}, 32'h705);
    repeat (4) @(negedge clk);
    check("R10 all responses seen", exp_q.size(), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule